// File: doc/BRIEF.md
# Integer ALU with Chained-Zero Carry Arithmetic

This block is the integer execution unit of a processor datapath. Each cycle it can accept one operation on two operands, a destination operand `a` and a source operand `b`. It computes a result and a new value for the four status flags: zero, negative, carry and overflow. The operations are clear, add, add-with-carry, subtract, subtract-with-borrow, compare, bitwise AND, and an address add that leaves the flags alone. The current flag vector comes in beside the operands. It supplies the carry-in for the chained operations and the zero flag they extend.

The chained operations are built for multi-word arithmetic. Add-with-carry and subtract-with-borrow only keep the zero flag set if it was already set on entry, so a final zero flag covers every word of a wide value. Subtract-with-borrow takes its carry from a plain unsigned comparison of the two operands and does not look at the borrow-in. Compare produces the flags of a subtract and never requests a result write.

A single registered stage holds the result, the result write-enable and the flags, and marks them with an output valid. A flag-update enable lets the issuing logic suppress the flag change for any operation.

Top module: `chained_alu`

## Requirements
- R1: An operation accepted with `in_valid` at a clock edge shows up on the outputs after that edge with `out_valid` high. After an edge with `in_valid` low, `out_valid` and `out_wr` are low. Reset clears `out_valid`, `out_wr`, `out_result` and `out_flags`.
- R2: Flag vector layout: bit 0 is Z, bit 1 is N, bit 2 is C, bit 3 is V. Clear (op 0) gives result 0 and flags 4'b0001.
- R3: Add (op 1) gives a+b. Z is set when the result is 0, N is the result MSB, C is the unsigned carry-out and V is the signed overflow.
- R4: Add-with-carry (op 2) gives a+b+C_in, with N set from the result MSB. V is set when a and b share a sign and the result sign differs.
- R5: For add-with-carry, the new Z is the old Z AND (result == 0). The new C is set when the result is below a or below b as unsigned values.
- R6: Subtract (op 3) gives a-b. Z is set when the result is 0, N is the result MSB, C is set when b > a unsigned, and V is the signed overflow of a-b.
- R7: Subtract-with-borrow (op 4) gives a-b-C_in. Z is the old Z AND (result == 0). C is set exactly when b > a unsigned, whatever C_in is. V is set when a and b differ in sign and the result sign differs from a.
- R8: Compare (op 5) gives the flags of subtract. `out_wr` is low.
- R9: AND (op 6) gives a&b, with Z and N taken from the result. C and V are cleared.
- R10: Address add (op 7) gives a+b, and `out_flags` equals `in_flags` whatever the flag-update enable is.
- R11: With `in_flag_en` low, `out_flags` equals `in_flags` for every operation. The result and the write-enable are unaffected.
- R12: With `out_valid` high, `out_wr` is high for every operation except compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 3 | Operation code (0 clear to 7 address add) |
| in_a | input | W | Destination operand |
| in_b | input | W | Source operand |
| in_flags | input | 4 | Current flags {V,C,N,Z} |
| in_flag_en | input | 1 | Allow the flag update |
| out_valid | output | 1 | Registered outputs are valid |
| out_result | output | W | Registered result |
| out_wr | output | 1 | Result should be written back |
| out_flags | output | 4 | Registered new flags {V,C,N,Z} |

## Verification
The hardest cases to reach are the chained operations. Their outcome depends on the incoming zero and carry flags together with operand pairs at the wrap boundaries. One example is add-with-carry where both operands are all ones and carry-in is set: the comparison rule then leaves C clear. Another is subtract-with-borrow with equal operands and a borrow-in, where C stays clear although the result wraps. The bench reaches these by sweeping every opcode over a set of boundary operand values, and crossing them with all sixteen incoming flag vectors and both enable values. It uses an 8-bit configuration, so that the wrap points lie among the swept values.

// File: rtl/alu_core_pkg.sv
package alu_core_pkg;
  typedef enum logic [2:0] {
    ALU_CLR  = 3'd0,
    ALU_ADD  = 3'd1,
    ALU_ADDC = 3'd2,
    ALU_SUB  = 3'd3,
    ALU_SUBC = 3'd4,
    ALU_CMP  = 3'd5,
    ALU_AND  = 3'd6,
    ALU_ADDR = 3'd7
  } alu_op_e;

  localparam int FLG_W = 4;
  localparam int FLG_Z = 0;
  localparam int FLG_N = 1;
  localparam int FLG_C = 2;
  localparam int FLG_V = 3;
endpackage

// File: rtl/alu_arith.sv
module alu_arith #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         add_cin,
  input  logic         sub_cin,
  output logic [W-1:0] sum,
  output logic         sum_cout,
  output logic [W-1:0] diff,
  output logic         src_gt_dst
);
  function automatic logic [W:0] add_ext(input logic [W-1:0] x, input logic [W-1:0] y,
                                         input logic c);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
  endfunction

  function automatic logic [W-1:0] sub_bw(input logic [W-1:0] x, input logic [W-1:0] y,
                                          input logic c);
    return x - y - {{(W-1){1'b0}}, c};
  endfunction

  logic [W:0] sum_ext;

  always_comb begin
    sum_ext    = add_ext(a, b, add_cin);
    sum        = sum_ext[W-1:0];
    sum_cout   = sum_ext[W];
    diff       = sub_bw(a, b, sub_cin);
    src_gt_dst = (b > a);
  end
endmodule

// File: rtl/alu_flagcalc.sv
module alu_flagcalc
  import alu_core_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e          op,
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  input  logic [FLG_W-1:0] flags_in,
  input  logic             flag_en,
  input  logic [W-1:0]     sum,
  input  logic             sum_cout,
  input  logic [W-1:0]     diff,
  input  logic             src_gt_dst,
  output logic [W-1:0]     res,
  output logic             wr,
  output logic [FLG_W-1:0] flags_out,
  output logic             chain_op
);
  localparam int M = W - 1;

  function automatic logic add_ovf(input logic [W-1:0] x, input logic [W-1:0] y,
                                   input logic [W-1:0] r);
    return (x[M] == y[M]) && (r[M] != x[M]);
  endfunction

  function automatic logic sub_ovf(input logic [W-1:0] x, input logic [W-1:0] y,
                                   input logic [W-1:0] r);
    return (x[M] != y[M]) && (r[M] != x[M]);
  endfunction

  logic [FLG_W-1:0] calc;

  always_comb begin
    res      = '0;
    wr       = 1'b1;
    calc     = flags_in;
    chain_op = 1'b0;
    unique case (op)
      ALU_CLR: begin
        res  = '0;
        calc = '0;
        calc[FLG_Z] = 1'b1;
      end
      ALU_ADD: begin
        res = sum;
        calc[FLG_Z] = (sum == '0);
        calc[FLG_N] = sum[M];
        calc[FLG_C] = sum_cout;
        calc[FLG_V] = add_ovf(a, b, sum);
      end
      ALU_ADDC: begin
        res      = sum;
        chain_op = 1'b1;
        calc[FLG_Z] = flags_in[FLG_Z] && (sum == '0);
        calc[FLG_N] = sum[M];
        calc[FLG_C] = (sum < a) || (sum < b);
        calc[FLG_V] = add_ovf(a, b, sum);
      end
      ALU_SUB, ALU_CMP: begin
        res = diff;
        wr  = (op != ALU_CMP);
        calc[FLG_Z] = (diff == '0);
        calc[FLG_N] = diff[M];
        calc[FLG_C] = src_gt_dst;
        calc[FLG_V] = sub_ovf(a, b, diff);
      end
      ALU_SUBC: begin
        res      = diff;
        chain_op = 1'b1;
        calc[FLG_Z] = flags_in[FLG_Z] && (diff == '0);
        calc[FLG_N] = diff[M];
        calc[FLG_C] = src_gt_dst;
        calc[FLG_V] = sub_ovf(a, b, diff);
      end
      ALU_AND: begin
        res = a & b;
        calc[FLG_Z] = ((a & b) == '0);
        calc[FLG_N] = a[M] & b[M];
        calc[FLG_C] = 1'b0;
        calc[FLG_V] = 1'b0;
      end
      default: begin
        res  = sum;
        calc = flags_in;
      end
    endcase
    flags_out = flag_en ? calc : flags_in;
  end
endmodule

// File: rtl/alu_outreg.sv
module alu_outreg
  import alu_core_pkg::*;
#(
  parameter int W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             d_valid,
  input  logic [W-1:0]     d_result,
  input  logic             d_wr,
  input  logic [FLG_W-1:0] d_flags,
  output logic             q_valid,
  output logic [W-1:0]     q_result,
  output logic             q_wr,
  output logic [FLG_W-1:0] q_flags
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid  <= 1'b0;
      q_result <= '0;
      q_wr     <= 1'b0;
      q_flags  <= '0;
    end else begin
      q_valid <= d_valid;
      q_wr    <= d_valid & d_wr;
      if (d_valid) begin
        q_result <= d_result;
        q_flags  <= d_flags;
      end
    end
  end
endmodule

// File: rtl/chained_alu.sv
module chained_alu
  import alu_core_pkg::*;
#(
  parameter int W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [2:0]       in_op,
  input  logic [W-1:0]     in_a,
  input  logic [W-1:0]     in_b,
  input  logic [FLG_W-1:0] in_flags,
  input  logic             in_flag_en,
  output logic             out_valid,
  output logic [W-1:0]     out_result,
  output logic             out_wr,
  output logic [FLG_W-1:0] out_flags
);
  alu_op_e          op;
  logic             add_cin;
  logic             sub_cin;
  logic [W-1:0]     sum;
  logic             sum_cout;
  logic [W-1:0]     diff;
  logic             src_gt_dst;
  logic [W-1:0]     nxt_result;
  logic             nxt_wr;
  logic [FLG_W-1:0] nxt_flags;
  logic             chain_op;

  assign op      = alu_op_e'(in_op);
  assign add_cin = (op == ALU_ADDC) & in_flags[FLG_C];
  assign sub_cin = (op == ALU_SUBC) & in_flags[FLG_C];

  alu_arith #(.W(W)) u_arith (
    .a          (in_a),
    .b          (in_b),
    .add_cin    (add_cin),
    .sub_cin    (sub_cin),
    .sum        (sum),
    .sum_cout   (sum_cout),
    .diff       (diff),
    .src_gt_dst (src_gt_dst)
  );

  alu_flagcalc #(.W(W)) u_flags (
    .op         (op),
    .a          (in_a),
    .b          (in_b),
    .flags_in   (in_flags),
    .flag_en    (in_flag_en),
    .sum        (sum),
    .sum_cout   (sum_cout),
    .diff       (diff),
    .src_gt_dst (src_gt_dst),
    .res        (nxt_result),
    .wr         (nxt_wr),
    .flags_out  (nxt_flags),
    .chain_op   (chain_op)
  );

  alu_outreg #(.W(W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .d_valid  (in_valid),
    .d_result (nxt_result),
    .d_wr     (nxt_wr),
    .d_flags  (nxt_flags),
    .q_valid  (out_valid),
    .q_result (out_result),
    .q_wr     (out_wr),
    .q_flags  (out_flags)
  );
endmodule

// File: rtl/chained_alu_chk.sv
module chained_alu_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [2:0]   in_op,
  input logic [W-1:0] in_a,
  input logic [W-1:0] in_b,
  input logic [3:0]   in_flags,
  input logic         in_flag_en,
  input logic         chain_op,
  input logic         out_valid,
  input logic [W-1:0] out_result,
  input logic         out_wr,
  input logic [3:0]   out_flags
);
  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !out_wr));
  // R12
  wr_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_wr |-> out_valid);
  // R2
  clear_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_flag_en && in_op == 3'd0) |=> (out_result == '0 && out_flags == 4'b0001));
  // R5 R7
  sticky_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_flag_en && chain_op && !in_flags[0]) |=> !out_flags[0]);
  // R7
  borrow_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_flag_en && in_op == 3'd4) |=> (out_flags[2] == ($past(in_b) > $past(in_a))));
  // R8
  compare_nowr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 3'd5) |=> !out_wr);
  // R9
  and_clears_cv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_flag_en && in_op == 3'd6) |=> (out_flags[3:2] == 2'b00));
  // R10 R11
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (!in_flag_en || in_op == 3'd7)) |=> (out_flags == $past(in_flags)));
endmodule

bind chained_alu chained_alu_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_op      (in_op),
  .in_a       (in_a),
  .in_b       (in_b),
  .in_flags   (in_flags),
  .in_flag_en (in_flag_en),
  .chain_op   (chain_op),
  .out_valid  (out_valid),
  .out_result (out_result),
  .out_wr     (out_wr),
  .out_flags  (out_flags)
);

// File: tb/test_chained_alu.sv
`timescale 1ns/1ps
module test_chained_alu;
  localparam int W = 8;
  localparam int MASK = (1 << W) - 1;
  localparam int SGN = 1 << (W - 1);

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [2:0]   in_op = '0;
  logic [W-1:0] in_a = '0;
  logic [W-1:0] in_b = '0;
  logic [3:0]   in_flags = '0;
  logic         in_flag_en = 1'b0;
  logic         out_valid;
  logic [W-1:0] out_result;
  logic         out_wr;
  logic [3:0]   out_flags;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  chained_alu #(.W(W)) i_chained_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_a(in_a), .in_b(in_b), .in_flags(in_flags), .in_flag_en(in_flag_en),
    .out_valid(out_valid), .out_result(out_result), .out_wr(out_wr),
    .out_flags(out_flags)
  );

  function automatic int pick(input int i);
    case (i)
      0: return 'h00;  1: return 'h01;  2: return 'h02;  3: return 'h0F;
      4: return 'h3F;  5: return 'h40;  6: return 'h7E;  7: return 'h7F;
      8: return 'h80;  9: return 'h81; 10: return 'hC0; 11: return 'hF0;
      12: return 'hFE; 13: return 'hFF; 14: return 'h55; default: return 'hAA;
    endcase
  endfunction

  function automatic string req_of(input int op);
    case (op)
      0: return "R2";  1: return "R3";  2: return "R4/R5"; 3: return "R6";
      4: return "R7";  5: return "R8";  6: return "R9";    default: return "R10";
    endcase
  endfunction

  function automatic int sval(input int x);
    return (x >= SGN) ? x - (1 << W) : x;
  endfunction

  // Model built from the requirements: returns {valid,wr,flags,result}
  function automatic int model(input int op, input int a, input int b,
                               input int fl, input bit en);
    int r, f, zi, ci, s;
    bit wr;
    zi = fl & 1;
    ci = (fl >> 2) & 1;
    wr = (op != 5);
    f  = fl;
    case (op)
      0: begin r = 0; f = 1; end
      1: begin
        r = (a + b) & MASK; s = sval(a) + sval(b);
        f = (r == 0) | ((r >= SGN) << 1) | (((a + b) > MASK) << 2)
          | (((s > SGN - 1) || (s < -SGN)) << 3);
      end
      2: begin
        r = (a + b + ci) & MASK;
        f = (zi & (r == 0)) | ((r >= SGN) << 1) | (((r < a) || (r < b)) << 2)
          | ((((a >= SGN) == (b >= SGN)) && ((r >= SGN) != (a >= SGN))) << 3);
      end
      3, 5: begin
        r = (a - b) & MASK; s = sval(a) - sval(b);
        f = (r == 0) | ((r >= SGN) << 1) | ((b > a) << 2)
          | (((s > SGN - 1) || (s < -SGN)) << 3);
      end
      4: begin
        r = (a - b - ci) & MASK;
        f = (zi & (r == 0)) | ((r >= SGN) << 1) | ((b > a) << 2)
          | ((((a >= SGN) != (b >= SGN)) && ((r >= SGN) != (a >= SGN))) << 3);
      end
      6: begin
        r = a & b;
        f = (r == 0) | ((r >= SGN) << 1);
      end
      default: begin r = (a + b) & MASK; f = fl; end
    endcase
    if (!en) f = fl;
    return (1 << (W + 5)) | (int'(wr) << (W + 4)) | (f << W) | r;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int pack_out();
    return (int'(out_valid) << (W + 5)) | (int'(out_wr) << (W + 4))
         | (int'(out_flags) << W) | int'(out_result);
  endfunction

  task automatic idle_check();
    @(negedge clk);
    in_valid = 1'b0;
    in_op = 3'd1;
    @(posedge clk); #1;
    // R1: idle cycle clears valid and write
    check("R1 idle", {30'd0, out_valid, out_wr}, 0);
  endtask

  initial begin
    #1;
    // R1: reset state
    check("R1 reset", pack_out(), 0);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    idle_check();
    for (int op = 0; op < 8; op++) begin
      for (int ai = 0; ai < 16; ai++) begin
        for (int bi = 0; bi < 16; bi++) begin
          for (int fl = 0; fl < 16; fl++) begin
            for (int en = 0; en < 2; en++) begin
              @(negedge clk);
              in_valid   = 1'b1;
              in_op      = op[2:0];
              in_a       = pick(ai);
              in_b       = pick(bi);
              in_flags   = fl[3:0];
              in_flag_en = en[0];
              @(posedge clk); #1;
              // R11 (enable low) and R12 (write) are covered by the same model
              if (en == 0)
                check("R11", pack_out(), model(op, pick(ai), pick(bi), fl, 1'b0));
              else
                check(req_of(op), pack_out(), model(op, pick(ai), pick(bi), fl, 1'b1));
            end
          end
        end
      end
      idle_check();
    end
    // R12: write-enable per opcode, operands fixed
    for (int op = 0; op < 8; op++) begin
      @(negedge clk);
      in_valid = 1'b1; in_op = op[2:0]; in_a = 8'h12; in_b = 8'h34;
      in_flags = 4'h0; in_flag_en = 1'b1;
      @(posedge clk); #1;
      check("R12", {31'd0, out_wr}, (op != 5) ? 1 : 0);
    end
    idle_check();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule